// File: doc/BRIEF.md
# Four-Channel Match Timer

The block is a memory-mapped timer peripheral with four independent counters, each as wide as a bus word by default. A single shared prescaler divides the peripheral clock into count ticks. Each counter can be started, held, forced to zero, and set to count up or down. Each counter is compared against its own match value. When they meet, three actions can be selected per channel: raise an interrupt flag, restart the counter from zero, or clear the counter's enable bit.

Software reaches every register over a simple 32-bit word bus. Address bits [3:2] select how a write is applied: a plain write, an OR of the written bits (set), a clear of the written bits, or a toggle of the written bits. Address bits above bit 3 pick the register. The interrupt output is a level signal. It stays high while any match flag is set.

Register indices (address = index × 0x10): 0 match flags, 1 control, 2 direction, 3 prescale limit, 4 prescale count (read only), 5 match actions, 6–9 match values 0–3, 10–13 counters 0–3 (read only).

Top module: `match_timer`

## Requirements
- R1: For writable registers, address bits [3:2] = 0 replace the value, 1 ORs the written bits in, 2 clears the written bits, and 3 toggles them. A read at any of the four addresses returns the register value.
- R2: After reset every register, every counter and the interrupt output are zero.
- R3: Control bit n (bits [3:0]) enables counter n. While it is 0 the counter holds its value. While it is 1 the counter moves by one on each prescaler tick.
- R4: While control bit 4+n is 1, counter n and the shared prescale count are forced to zero from the next clock edge onward.
- R5: Direction field n sits at bits [4n+3:4n]. The value 1 makes counter n count down. The value 0 makes it count up.
- R6: With a prescale limit of N, an enabled counter advances once every N+1 clocks. A limit of 0 gives one advance per clock.
- R7: A match occurs on an advance cycle when an enabled counter equals its match value. If match-action bit 3n is set, flag n is set, and it then stays set. The interrupt output is high exactly when any flag is set.
- R8: If match-action bit 3n+1 is set, a match loads counter n with zero instead of advancing it.
- R9: If match-action bit 3n+2 is set, a match clears enable bit n and the counter keeps its value (or zero when R8 also applies).
- R10: A plain write to the flag register clears each flag whose written bit is 1 and leaves the others unchanged.
- R11: A counter passing between all-ones and zero in either direction sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: register index in [7:4], write mode in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level interrupt, high while any match flag is set |

## Verification
The assertions assume that a bus write and a hardware event may land on the same register in the same cycle, and they expect the hardware event to win. They also assume the prescale limit may be changed while the prescaler is running, so they never require the prescale count to stay below the limit. The bench keeps each counter's run isolated: it pulses the channel's reset bit before every run, times the start and stop writes against a cycle counter, and derives the expected count from that interval, the prescale limit and the direction. Match values are placed so that a wrap through zero can never coincide with a real match.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_FLIP  = 2'd3
    } mt_op_e;

    localparam int REG_FLAGS  = 0;
    localparam int REG_CTRL   = 1;
    localparam int REG_DIR    = 2;
    localparam int REG_PRE    = 3;
    localparam int REG_PCNT   = 4;
    localparam int REG_ACT    = 5;
    localparam int REG_MATCH0 = 6;

    function automatic logic [BUS_W-1:0] alias_apply(
        input logic [BUS_W-1:0] cur,
        input logic [BUS_W-1:0] wd,
        input mt_op_e           op
    );
        case (op)
            OP_SET:   alias_apply = cur | wd;
            OP_CLEAR: alias_apply = cur & ~wd;
            OP_FLIP:  alias_apply = cur ^ wd;
            default:  alias_apply = wd;
        endcase
    endfunction
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [CNT_W-1:0] limit,
    output logic             tick,
    output logic [CNT_W-1:0] pcount
);
    typedef struct packed {
        logic [CNT_W-1:0] pc;
    } pre_t;

    pre_t s_q, s_d;

    assign tick   = (s_q.pc >= limit);
    assign pcount = s_q.pc;

    always_comb begin
        s_d = s_q;
        if (clr)
            s_d.pc = '0;
        else if (run)
            s_d.pc = tick ? '0 : s_q.pc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_PRESCALE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pcount == '0));  // R4
    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && tick) |=> (pcount == '0));  // R6
endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             tick,
    input  logic             down,
    input  logic [CNT_W-1:0] match_val,
    input  logic             act_rst,
    input  logic             act_stop,
    output logic             hit,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } chan_t;

    chan_t s_q, s_d;
    logic  adv;

    assign adv   = en && tick && !clr;
    assign hit   = adv && (s_q.cnt == match_val);
    assign count = s_q.cnt;

    always_comb begin
        s_d = s_q;
        if (clr)
            s_d.cnt = '0;
        else if (adv) begin
            if (hit && act_rst)
                s_d.cnt = '0;
            else if (hit && act_stop)
                s_d.cnt = s_q.cnt;
            else if (down)
                s_d.cnt = s_q.cnt - 1'b1;
            else
                s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));  // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(count));  // R3
    AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act_rst) |=> (count == '0));  // R8
    AST_SILENT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !hit && !down && (count == '1)) |=> (count == '0));  // R11
endmodule

// File: rtl/match_timer.sv
module match_timer #(
    parameter int NCH   = 4,
    parameter int CNT_W = 32,
    parameter int AW    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_we,
    input  logic [AW-1:0]           bus_addr,
    input  logic [mt_pkg::BUS_W-1:0] bus_wdata,
    output logic [mt_pkg::BUS_W-1:0] bus_rdata,
    output logic                    irq
);
    import mt_pkg::*;

    localparam int CTL_W      = 2 * NCH;
    localparam int DIR_W      = 4 * NCH;
    localparam int ACT_W      = 3 * NCH;
    localparam int IDX_W      = AW - 4;
    localparam int REG_COUNT0 = REG_MATCH0 + NCH;

    typedef struct packed {
        logic [NCH-1:0]            flags;
        logic [CTL_W-1:0]          ctrl;
        logic [DIR_W-1:0]          dir;
        logic [CNT_W-1:0]          pre;
        logic [ACT_W-1:0]          act;
        logic [NCH-1:0][CNT_W-1:0] mval;
    } regs_t;

    regs_t r_q, r_d;

    logic [NCH-1:0]            hit;
    logic [NCH-1:0]            stop_mask;
    logic [NCH-1:0]            flag_set;
    logic [NCH-1:0][CNT_W-1:0] cnt;
    logic                      tick;
    logic [CNT_W-1:0]          pcount;
    logic                      wr;
    int                        idx;
    mt_op_e                    op;

    assign wr  = bus_sel && bus_we;
    assign idx = int'(bus_addr[AW-1:4]);
    assign op  = mt_op_e'(bus_addr[3:2]);
    assign irq = |r_q.flags;

    mt_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (|r_q.ctrl[NCH-1:0]),
        .clr    (|r_q.ctrl[CTL_W-1:NCH]),
        .limit  (r_q.pre),
        .tick   (tick),
        .pcount (pcount)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        mt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (r_q.ctrl[NCH+n]),
            .en        (r_q.ctrl[n]),
            .tick      (tick),
            .down      (r_q.dir[4*n +: 4] == 4'd1),
            .match_val (r_q.mval[n]),
            .act_rst   (r_q.act[3*n+1]),
            .act_stop  (r_q.act[3*n+2]),
            .hit       (hit[n]),
            .count     (cnt[n])
        );
        assign stop_mask[n] = hit[n] && r_q.act[3*n+2];
        assign flag_set[n]  = hit[n] && r_q.act[3*n];

        AST_STOP_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
            stop_mask[n] |=> !r_q.ctrl[n]);  // R9
        AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            flag_set[n] |=> (r_q.flags[n] && irq));  // R7
    end

    always_comb begin
        r_d = r_q;
        if (wr) begin
            if (idx == REG_FLAGS) begin
                if (op == OP_WRITE)
                    r_d.flags = r_q.flags & ~bus_wdata[NCH-1:0];
                else
                    r_d.flags = NCH'(alias_apply(BUS_W'(r_q.flags), bus_wdata, op));
            end
            if (idx == REG_CTRL)
                r_d.ctrl = CTL_W'(alias_apply(BUS_W'(r_q.ctrl), bus_wdata, op));
            if (idx == REG_DIR)
                r_d.dir = DIR_W'(alias_apply(BUS_W'(r_q.dir), bus_wdata, op));
            if (idx == REG_PRE)
                r_d.pre = CNT_W'(alias_apply(BUS_W'(r_q.pre), bus_wdata, op));
            if (idx == REG_ACT)
                r_d.act = ACT_W'(alias_apply(BUS_W'(r_q.act), bus_wdata, op));
            for (int n = 0; n < NCH; n++) begin
                if (idx == REG_MATCH0 + n)
                    r_d.mval[n] = CNT_W'(alias_apply(BUS_W'(r_q.mval[n]), bus_wdata, op));
            end
        end
        r_d.flags          = r_d.flags | flag_set;
        r_d.ctrl[NCH-1:0]  = r_d.ctrl[NCH-1:0] & ~stop_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (idx == REG_FLAGS) bus_rdata = BUS_W'(r_q.flags);
        if (idx == REG_CTRL)  bus_rdata = BUS_W'(r_q.ctrl);
        if (idx == REG_DIR)   bus_rdata = BUS_W'(r_q.dir);
        if (idx == REG_PRE)   bus_rdata = BUS_W'(r_q.pre);
        if (idx == REG_PCNT)  bus_rdata = BUS_W'(pcount);
        if (idx == REG_ACT)   bus_rdata = BUS_W'(r_q.act);
        for (int n = 0; n < NCH; n++) begin
            if (idx == REG_MATCH0 + n) bus_rdata = BUS_W'(r_q.mval[n]);
            if (idx == REG_COUNT0 + n) bus_rdata = BUS_W'(cnt[n]);
        end
    end

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr || idx != REG_FLAGS) |=> ((r_q.flags & $past(r_q.flags)) == $past(r_q.flags)));  // R7
    AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == REG_FLAGS && op == OP_WRITE && flag_set == '0)
        |=> (r_q.flags == ($past(r_q.flags) & ~$past(bus_wdata[NCH-1:0]))));  // R10
endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    match_timer #(.NCH(NCH), .CNT_W(32), .AW(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    localparam int I_FLAGS = 0, I_CTRL = 1, I_DIR = 2, I_PRE = 3, I_PCNT = 4,
                   I_ACT = 5, I_MATCH0 = 6, I_COUNT0 = 10;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bw(input int idx, input int op, input logic [31:0] d, output int c);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1;
        bus_addr = {idx[3:0], op[1:0], 2'b00}; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        c = cyc;
    endtask

    task automatic wr(input int idx, input int op, input logic [31:0] d);
        int c;
        bw(idx, op, d, c);
    endtask

    task automatic br(input int idx, input int op, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0;
        bus_addr = {idx[3:0], op[1:0], 2'b00};
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic fresh(input int ch);
        wr(I_CTRL, 0, 32'h1 << (NCH + ch));
        wr(I_CTRL, 0, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int e, f, d1, d2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R2: reset state
        for (int i = 0; i < 14; i++) begin
            br(i, 0, v);
            check("R2 reset register", v, 32'h0);
        end
        check("R2 irq after reset", {31'h0, irq}, 32'h0);

        // R1: alias write modes on match value 0
        wr(I_MATCH0, 0, 32'h0F0F0F0F);
        wr(I_MATCH0, 1, 32'h30000000);
        br(I_MATCH0, 0, v); check("R1 set alias", v, 32'h3F0F0F0F);
        wr(I_MATCH0, 2, 32'h0000000F);
        br(I_MATCH0, 1, v); check("R1 clear alias", v, 32'h3F0F0F00);
        wr(I_MATCH0, 3, 32'hFFFF0000);
        br(I_MATCH0, 3, v); check("R1 toggle alias", v, 32'hC0F00F00);
        br(I_MATCH0, 2, v); check("R1 read at clear alias", v, 32'hC0F00F00);
        wr(I_MATCH0, 0, 32'h0);

        // R3 R5 R6: sweep channels, prescale limits, directions, run lengths
        for (int ch = 0; ch < NCH; ch++) begin
            for (int pre = 0; pre < 4; pre++) begin
                for (int dn = 0; dn < 2; dn++) begin
                    for (int li = 0; li < 2; li++) begin
                        logic [31:0] exp;
                        fresh(ch);
                        wr(I_PRE, 0, pre);
                        wr(I_DIR, 0, dn << (4 * ch));
                        bw(I_CTRL, 1, 32'h1 << ch, e);
                        repeat (li == 0 ? 3 : 11) @(posedge clk);
                        bw(I_CTRL, 2, 32'h1 << ch, f);
                        exp = 32'((f - e) / (pre + 1));
                        if (dn == 1) exp = -exp;
                        br(I_COUNT0 + ch, 0, v);
                        check(dn ? "R5 R6 down count" : "R3 R6 up count", v, exp);
                    end
                end
            end
        end
        // R3: disabled counter holds
        br(I_COUNT0 + 3, 0, d1[31:0]);
        repeat (7) @(posedge clk);
        br(I_COUNT0 + 3, 0, v);
        check("R3 disabled holds", v, 32'(d1));
        wr(I_PRE, 0, 0);
        wr(I_DIR, 0, 0);

        // R4: reset bit holds counter and prescale count at zero
        fresh(0);
        wr(I_PRE, 0, 2);
        wr(I_CTRL, 1, 32'h1);
        repeat (10) @(posedge clk);
        wr(I_CTRL, 1, 32'h1 << NCH);
        br(I_COUNT0, 0, v); check("R4 counter cleared", v, 0);
        repeat (5) @(posedge clk);
        br(I_COUNT0, 0, v); check("R4 counter held", v, 0);
        br(I_PCNT, 0, v); check("R4 prescale cleared", v, 0);
        wr(I_PRE, 0, 0);
        bw(I_CTRL, 2, 32'h1 << NCH, e);
        repeat (6) @(posedge clk);
        bw(I_CTRL, 2, 32'h1, f);
        br(I_COUNT0, 0, v); check("R4 counts after release", v, 32'(f - e));

        // R7 R8: ch1 interrupt + restart on match 5
        fresh(1);
        wr(I_MATCH0 + 1, 0, 5);
        wr(I_ACT, 0, 32'h3 << 3);
        bw(I_CTRL, 1, 32'h2, e);
        repeat (20) @(posedge clk);
        bw(I_CTRL, 2, 32'h2, f);
        br(I_COUNT0 + 1, 0, v); check("R8 restart on match", v, 32'((f - e) % 6));
        br(I_FLAGS, 0, v); check("R7 flag set", v, 32'h2);
        check("R7 irq high", {31'h0, irq}, 1);

        // R9: ch2 stop on match 7
        fresh(2);
        wr(I_MATCH0 + 2, 0, 7);
        wr(I_ACT, 0, 32'h4 << 6);
        wr(I_CTRL, 1, 32'h4);
        repeat (20) @(posedge clk);
        br(I_CTRL, 0, v); check("R9 enable cleared", v & 32'h4, 0);
        br(I_COUNT0 + 2, 0, v); check("R9 counter held at match", v, 7);
        br(I_FLAGS, 0, v); check("R9 no flag without int", v & 32'h4, 0);

        // R8 R9 R7: ch3 all actions on match 3
        fresh(3);
        wr(I_MATCH0 + 3, 0, 3);
        wr(I_ACT, 0, 32'h7 << 9);
        wr(I_CTRL, 1, 32'h8);
        repeat (12) @(posedge clk);
        br(I_CTRL, 0, v); check("R9 enable cleared all actions", v & 32'h8, 0);
        br(I_COUNT0 + 3, 0, v); check("R8 zero after stop+restart", v, 0);
        br(I_FLAGS, 0, v); check("R7 two flags set", v, 32'hA);

        // R10: write-one-to-clear
        wr(I_FLAGS, 0, 32'h2);
        br(I_FLAGS, 0, v); check("R10 clear one flag", v, 32'h8);
        check("R7 irq with remaining flag", {31'h0, irq}, 1);
        wr(I_FLAGS, 0, 32'h8);
        br(I_FLAGS, 0, v); check("R10 clear last flag", v, 0);
        check("R7 irq low", {31'h0, irq}, 0);

        // R11: wrap both ways sets no flag
        wr(I_ACT, 0, 32'h1);
        fresh(0);
        wr(I_MATCH0, 0, 100);
        wr(I_DIR, 0, 1);
        bw(I_CTRL, 1, 32'h1, e);
        bw(I_CTRL, 2, 32'h1, f);
        d1 = f - e;
        br(I_COUNT0, 0, v); check("R11 wrap down", v, 32'(-d1));
        wr(I_DIR, 0, 0);
        bw(I_CTRL, 1, 32'h1, e);
        repeat (d1 + 4) @(posedge clk);
        bw(I_CTRL, 2, 32'h1, f);
        d2 = f - e;
        br(I_COUNT0, 0, v); check("R11 wrap up", v, 32'(d2 - d1));
        br(I_FLAGS, 0, v); check("R11 no flag on wrap", v, 0);
        check("R11 irq low", {31'h0, irq}, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule